// File: doc/BRIEF.md
# Eight-bit compare timer

This block is an 8-bit up/down counter that advances on enables from a free-running prescaler, compares its value against one compare register, and drives a single waveform pin plus a sticky compare flag. One control byte picks the counting mode, the pin action on a match and the tick rate. The same byte carries a write-only strobe that forces one compare action onto the pin.

Software reaches the block through a word-wide register port with four addresses. A write lands at the clock edge. A read returns data one cycle after the address is presented. Four counting modes are supported: a free-running wrap, clear-on-compare with the compare value as the period, single-slope PWM and dual-slope (phase-correct) PWM. In both PWM modes the compare value written by software is held in a shadow register and takes effect only at the top of the count.

Top module: `tmr8_cmp`

## Requirements
- R1: After synchronous reset every register reads zero, the counter is stopped, and `wave_out` and `cmp_flag` are 0.
- R2: The control field `ctl[2:0]` selects the tick rate. 0 holds the counter. Codes 1 to 7 advance it once every 1, 8, 32, 64, 128, 256 and 1024 clocks of a free-running prescaler that is cleared only by reset.
- R3: The mode is the pair {ctl[3], ctl[6]}: 00 wrap, 01 phase-correct PWM, 10 clear-on-compare, 11 single-slope PWM. In wrap mode each tick increments the counter and 0xFF rolls to 0x00. A tick taken while the counter equals the active compare value sets `cmp_flag`.
- R4: In clear-on-compare mode, a tick taken while the counter equals the compare value loads 0 instead of incrementing.
- R5: In single-slope PWM the counter wraps at 0xFF. With `ctl[5:4]`=10 the pin clears on a match and sets on the tick at 0xFF. 11 inverts both actions, and the action at 0xFF wins when both fall on one tick.
- R6: In phase-correct PWM the counter rises to 0xFF, then falls to 0x00, and repeats. With `ctl[5:4]`=10 the pin clears on a match while rising and sets on a match while falling. 11 inverts this.
- R7: A compare write (address 2) updates the active compare value at once in the two non-PWM modes. In the PWM modes it fills only a shadow, which is copied to the active value on the tick at 0xFF. Address 2 reads back the shadow.
- R8: In the non-PWM modes `ctl[5:4]` selects the pin action on a match: 00 pin off (reads 0), 01 toggle, 10 clear, 11 set. In the PWM modes, 00 and 01 turn the pin off.
- R9: Writing control with `ctl[7]`=1 and `ctl[6]`=0 applies the newly written non-PWM pin action at once. This forced action sets no flag and leaves the counter unchanged. With `ctl[6]`=1 the strobe has no effect.
- R10: The address map is 0 control, 1 counter, 2 compare, 3 flag (`cmp_flag` in bit 0). The strobe bit 7 of control always reads 0.
- R11: A counter write (address 1) loads the data and suppresses any match on the next tick.
- R12: Writing address 3 with data bit 0 set clears `cmp_flag`. A match in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after `addr` |
| wave_out | output | 1 | Compare waveform pin |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The counter-turn and clear-on-compare properties assume that no counter write coincides with the tick being checked, and they exclude that case themselves. The flag properties take the address and write strobe to be known values whenever reset is low. The bench drives every input at the falling edge from tasks and never leaves the bus undriven. Its scenarios write the strobe in PWM modes only to show that it is ignored. A behavioural model in the bench tracks the prescaler phase, the shadow register and the count direction, and checks the pin, the flag and the read port on every clock.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 10;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {
    MODE_WRAP  = 2'b00,
    MODE_PHASE = 2'b01,
    MODE_CLR   = 2'b10,
    MODE_FAST  = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  function automatic logic is_pwm(input tmr_mode_e m);
    return (m == MODE_PHASE) || (m == MODE_FAST);
  endfunction
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  function automatic logic [PW-1:0] mask_for(input logic [2:0] s);
    int sh;
    case (s)
      3'd1:    sh = 0;
      3'd2:    sh = 3;
      3'd3:    sh = 5;
      3'd4:    sh = 6;
      3'd5:    sh = 7;
      3'd6:    sh = 8;
      default: sh = 10;
    endcase
    return PW'((64'd1 << sh) - 64'd1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign mask = mask_for(sel);
  assign tick = (sel != 3'd0) && ((pre_q & mask) == mask);
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
  import tmr8_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  tmr_mode_e    mode,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] shadow_q,
  output logic         match,
  output logic         top_evt,
  output logic         rising
);
  localparam logic [W-1:0] TOPV = {W{1'b1}};

  logic [W-1:0] cnt_d, act_q, act_d, shadow_d;
  logic         blk_q, blk_d, up_q, up_d, pwm;

  assign pwm     = is_pwm(mode);
  assign match   = tick && (cnt_q == act_q) && !blk_q;
  assign top_evt = tick && !cnt_wr && (cnt_q == TOPV);
  assign rising  = up_q;

  always_comb begin
    cnt_d = cnt_q;
    blk_d = blk_q;
    up_d  = up_q;
    if (cnt_wr) begin
      cnt_d = wdata;
      blk_d = 1'b1;
    end else if (tick) begin
      blk_d = 1'b0;
      case (mode)
        MODE_CLR: cnt_d = (cnt_q == act_q) ? '0 : cnt_q + 1'b1;
        MODE_PHASE: begin
          if (up_q) begin
            if (cnt_q == TOPV) begin
              up_d  = 1'b0;
              cnt_d = cnt_q - 1'b1;
            end else cnt_d = cnt_q + 1'b1;
          end else begin
            if (cnt_q == '0) begin
              up_d  = 1'b1;
              cnt_d = cnt_q + 1'b1;
            end else cnt_d = cnt_q - 1'b1;
          end
        end
        default: cnt_d = cnt_q + 1'b1;
      endcase
    end
    if (mode != MODE_PHASE) up_d = 1'b1;
  end

  always_comb begin
    shadow_d = cmp_wr ? wdata : shadow_q;
    act_d    = act_q;
    if (pwm && top_evt)  act_d = shadow_q;
    if (cmp_wr && !pwm)  act_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      act_q    <= '0;
      shadow_q <= '0;
      blk_q    <= 1'b0;
      up_q     <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      act_q    <= act_d;
      shadow_q <= shadow_d;
      blk_q    <= blk_d;
      up_q     <= up_d;
    end
  end

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(cnt_q))
    else $error("counter moved without a tick");

  assert_clr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && mode == MODE_CLR && cnt_q == act_q) |=> (cnt_q == '0))
    else $error("clear-on-compare did not return to zero");

  assert_phase_turn_R6: assert property (@(posedge clk) disable iff (rst)
    (top_evt && mode == MODE_PHASE && up_q) |=> (cnt_q == TOPV - 1'b1 && !up_q))
    else $error("phase-correct count failed to turn at top");

  assert_wr_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> !match)
    else $error("match not suppressed after counter write");

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pwm && !top_evt) |=> $stable(act_q))
    else $error("active compare changed away from top in PWM");

  assert_direct_load_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_wr && !pwm) |=> (act_q == $past(wdata)))
    else $error("non-PWM compare write not applied");
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tmr_mode_e mode,
  input  logic [1:0] act,
  input  logic      match,
  input  logic      top_evt,
  input  logic      rising,
  input  logic      force_evt,
  input  logic [1:0] force_act,
  input  logic [1:0] pin_act,
  input  logic      pin_pwm,
  output logic      wave_out
);
  logic oc_q, oc_d, conn;

  function automatic logic plain_act(input logic [1:0] a, input logic cur);
    case (a)
      2'b01:   return !cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  always_comb begin
    oc_d = oc_q;
    case (mode)
      MODE_FAST: begin
        if (match && act[1])   oc_d = act[0];
        if (top_evt && act[1]) oc_d = !act[0];
      end
      MODE_PHASE: begin
        if (match && act[1]) oc_d = rising ? act[0] : !act[0];
      end
      default: begin
        if (match) oc_d = plain_act(act, oc_q);
      end
    endcase
    if (force_evt) oc_d = plain_act(force_act, oc_q);
  end

  always_ff @(posedge clk) begin
    if (rst) oc_q <= 1'b0;
    else     oc_q <= oc_d;
  end

  assign conn     = (pin_act != 2'b00) && !(pin_pwm && pin_act == 2'b01);
  assign wave_out = oc_q && conn;

  assert_force_set_R9: assert property (@(posedge clk) disable iff (rst)
    (force_evt && force_act == 2'b11) |=> oc_q)
    else $error("forced set did not reach the pin state");
endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       wave_out,
  output logic       cmp_flag
);
  logic [6:0]   ctl_q;
  logic [7:0]   cnt, shadow;
  logic         tick, match, top_evt, rising;
  logic         ctl_wr, cnt_wr, cmp_wr, flag_clr, force_evt;
  tmr_mode_e    mode, new_mode;

  assign mode      = tmr_mode_e'({ctl_q[3], ctl_q[6]});
  assign new_mode  = tmr_mode_e'({wdata[3], wdata[6]});
  assign ctl_wr    = wr_en && addr == A_CTL;
  assign cnt_wr    = wr_en && addr == A_CNT;
  assign cmp_wr    = wr_en && addr == A_CMP;
  assign flag_clr  = wr_en && addr == A_FLAG && wdata[0];
  assign force_evt = ctl_wr && wdata[7] && !wdata[6];

  tmr8_prescale #(.PW(PRE_W)) i_pre (
    .clk(clk), .rst(rst), .sel(ctl_q[2:0]), .tick(tick)
  );

  tmr8_count #(.W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode),
    .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .wdata(wdata),
    .cnt_q(cnt), .shadow_q(shadow), .match(match),
    .top_evt(top_evt), .rising(rising)
  );

  logic pin_pwm;
  assign pin_pwm = is_pwm(mode);

  tmr8_wave i_wave (
    .clk(clk), .rst(rst), .mode(mode), .act(ctl_q[5:4]),
    .match(match), .top_evt(top_evt), .rising(rising),
    .force_evt(force_evt), .force_act(wdata[5:4]),
    .pin_act(ctl_q[5:4]), .pin_pwm(pin_pwm), .wave_out(wave_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      cmp_flag <= 1'b0;
      rdata    <= '0;
    end else begin
      if (ctl_wr) ctl_q <= wdata[6:0];
      if (match)         cmp_flag <= 1'b1;
      else if (flag_clr) cmp_flag <= 1'b0;
      case (addr)
        A_CTL:   rdata <= {1'b0, ctl_q};
        A_CNT:   rdata <= cnt;
        A_CMP:   rdata <= shadow;
        default: rdata <= {7'b0, cmp_flag};
      endcase
    end
  end

  logic unused_mode;
  assign unused_mode = ^new_mode;

  assert_force_noflag_R9: assert property (@(posedge clk) disable iff (rst)
    (force_evt && !match && !flag_clr) |=> (cmp_flag == $past(cmp_flag)))
    else $error("forced compare touched the flag");

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !match) |=> !cmp_flag)
    else $error("flag not cleared");

  assert_match_sets_R3: assert property (@(posedge clk) disable iff (rst)
    match |=> cmp_flag)
    else $error("match did not set flag");
endmodule

// File: tb/test_tmr8_cmp.sv
module test_tmr8_cmp;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       wave_out, cmp_flag;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit run_cmp = 0;

  always #4 clk = ~clk;

  tmr8_cmp i_tmr8_cmp (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wave_out(wave_out), .cmp_flag(cmp_flag)
  );

  // behavioural reference model
  int m_pre, m_cnt, m_ocr, m_buf, m_ctl, m_rd;
  bit m_blk, m_up, m_oc, m_flag;

  function automatic int div_of(input int cs);
    case (cs)
      1: return 1;   2: return 8;   3: return 32;  4: return 64;
      5: return 128; 6: return 256; default: return 1024;
    endcase
  endfunction

  function automatic bit act_plain(input int a, input bit cur);
    if (a == 1) return !cur;
    if (a == 2) return 1'b0;
    if (a == 3) return 1'b1;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_ocr = 0; m_buf = 0; m_ctl = 0; m_rd = 0;
      m_blk = 0; m_up = 1; m_oc = 0; m_flag = 0;
    end else begin
      int md, cs, com, nb, no, nc;
      bit tick, match, top, pwm, cwr, owr, kwr, fclr, nu, nblk, noc, nf;
      md  = ((m_ctl >> 3) & 1) * 2 + ((m_ctl >> 6) & 1);
      cs  = m_ctl & 7;
      com = (m_ctl >> 4) & 3;
      tick = (cs != 0) && ((m_pre % div_of(cs)) == div_of(cs) - 1);
      m_pre = (m_pre + 1) % 1024;
      cwr = wr_en && addr == 1; owr = wr_en && addr == 2;
      kwr = wr_en && addr == 0; fclr = wr_en && addr == 3 && wdata[0];
      pwm = (md == 1) || (md == 3);
      match = tick && m_cnt == m_ocr && !m_blk;
      top = tick && !cwr && m_cnt == 255;
      case (addr)
        2'd0: m_rd = m_ctl;
        2'd1: m_rd = m_cnt;
        2'd2: m_rd = m_buf;
        default: m_rd = m_flag;
      endcase
      noc = m_oc;
      if (md == 3) begin
        if (match && com[1]) noc = com[0];
        if (top && com[1]) noc = !com[0];
      end else if (md == 1) begin
        if (match && com[1]) noc = m_up ? com[0] : !com[0];
      end else if (match) noc = act_plain(com, m_oc);
      if (kwr && wdata[7] && !wdata[6]) noc = act_plain(wdata[5:4], m_oc);
      no = m_ocr; nb = m_buf;
      if (owr) nb = wdata;
      if (pwm && top) no = m_buf;
      if (owr && !pwm) no = wdata;
      nc = m_cnt; nblk = m_blk; nu = m_up;
      if (cwr) begin nc = wdata; nblk = 1; end
      else if (tick) begin
        nblk = 0;
        if (md == 2) nc = (m_cnt == m_ocr) ? 0 : (m_cnt + 1) % 256;
        else if (md == 1) begin
          if (m_up) begin
            if (m_cnt == 255) begin nu = 0; nc = 254; end else nc = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin nu = 1; nc = 1; end else nc = m_cnt - 1;
          end
        end else nc = (m_cnt + 1) % 256;
      end
      if (md != 1) nu = 1;
      nf = match ? 1'b1 : (fclr ? 1'b0 : m_flag);
      if (kwr) m_ctl = wdata & 8'h7F;
      m_cnt = nc; m_blk = nblk; m_up = nu; m_ocr = no; m_buf = nb;
      m_oc = noc; m_flag = nf;
    end
  end

  function automatic bit exp_wave();
    int md, com;
    bit pwm;
    md  = ((m_ctl >> 3) & 1) * 2 + ((m_ctl >> 6) & 1);
    com = (m_ctl >> 4) & 3;
    pwm = (md == 1) || (md == 3);
    return m_oc && com != 0 && !(pwm && com == 1);
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      check(cur_req, "wave_out", wave_out, exp_wave());
      check(cur_req, "cmp_flag", cmp_flag, m_flag);
      check(cur_req, "rdata", rdata, m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 8'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    addr = a;
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cur_req = "R1";
    check("R1", "wave_out", wave_out, 0);
    check("R1", "cmp_flag", cmp_flag, 0);
    rd(2'd0, v); check("R1", "ctl", v, 0);
    rd(2'd1, v); check("R1", "cnt", v, 0);
    idle(20, 2'd1); rd(2'd1, v); check("R1", "cnt stopped", v, 0);
    run_cmp = 1;

    // R10 strobe reads zero, R9 force in stopped wrap mode
    cur_req = "R10";
    wr(2'd0, 8'hB0);
    check("R9", "forced set", wave_out, 1);
    check("R9", "no flag", cmp_flag, 0);
    rd(2'd0, v); check("R10", "strobe reads 0", v, 8'h30);

    // R3 wrap mode with toggle, R8
    cur_req = "R3";
    wr(2'd2, 8'h40);
    wr(2'd0, 8'h11);
    idle(700, 2'd1);
    cur_req = "R12";
    rd(2'd3, v); check("R12", "flag set", v, 1);
    wr(2'd3, 8'h01);
    rd(2'd3, v); check("R12", "flag cleared", v, 0);
    cur_req = "R8";
    wr(2'd0, 8'h21); idle(600, 2'd1);
    wr(2'd0, 8'h31); idle(600, 2'd1);
    wr(2'd0, 8'h01); idle(300, 2'd3);

    // R2 prescale sweep
    cur_req = "R2";
    for (int c = 2; c <= 7; c++) begin
      wr(2'd0, 8'h10 | c[7:0]);
      idle((c == 7) ? 3000 : 1500, 2'd1);
    end
    wr(2'd0, 8'h10);
    rd(2'd1, v);
    idle(200, 2'd1);
    check("R2", "held", rdata, v);

    // R4 clear-on-compare
    cur_req = "R4";
    wr(2'd2, 8'd5);
    wr(2'd0, 8'h19);
    idle(200, 2'd1);
    wr(2'd0, 8'h1A);
    idle(400, 2'd1);
    wr(2'd2, 8'd200);
    wr(2'd1, 8'd210);
    wr(2'd0, 8'h19);
    idle(600, 2'd1);

    // R11 counter write blocks the next match
    cur_req = "R11";
    wr(2'd2, 8'd5);
    wr(2'd3, 8'h01);
    wr(2'd1, 8'd5);
    @(negedge clk);
    check("R11", "blocked flag", cmp_flag, 0);
    idle(40, 2'd1);

    // R9 force in clear-on-compare keeps the counter
    cur_req = "R9";
    wr(2'd0, 8'h28);
    wr(2'd1, 8'd7);
    wr(2'd2, 8'd7);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'hB8);
    check("R9", "forced set", wave_out, 1);
    check("R9", "no flag", cmp_flag, 0);
    rd(2'd1, v); check("R9", "counter kept", v, 7);
    wr(2'd0, 8'h98);
    check("R9", "forced toggle", wave_out, 0);

    // R5 single-slope PWM, R7 shadow
    cur_req = "R5";
    wr(2'd0, 8'h69);
    wr(2'd2, 8'h80);
    idle(700, 2'd1);
    cur_req = "R7";
    wr(2'd2, 8'h30);
    rd(2'd2, v); check("R7", "shadow readback", v, 8'h30);
    idle(700, 2'd2);
    cur_req = "R5";
    wr(2'd0, 8'h79); idle(600, 2'd1);
    wr(2'd2, 8'hFF); idle(600, 2'd1);
    wr(2'd2, 8'h00); idle(600, 2'd1);
    cur_req = "R9";
    wr(2'd0, 8'hF9); idle(300, 2'd0);
    cur_req = "R8";
    wr(2'd0, 8'h59); idle(300, 2'd1);

    // R6 phase-correct PWM
    cur_req = "R6";
    wr(2'd0, 8'h61);
    wr(2'd2, 8'h60);
    idle(1200, 2'd1);
    wr(2'd2, 8'h10);
    idle(1200, 2'd1);
    wr(2'd0, 8'h71);
    wr(2'd2, 8'h00);
    idle(1200, 2'd1);
    wr(2'd0, 8'hE1);
    idle(600, 2'd3);

    // R3 back to wrap with slow tick
    cur_req = "R3";
    wr(2'd0, 8'h12);
    wr(2'd2, 8'h03);
    idle(2500, 2'd1);

    run_cmp = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule